// File: doc/BRIEF.md
# HDLC Receive Framer with Station Address Filter

This block takes a serial bit stream, one bit per strobe, and turns it into tagged bytes for a receive queue. It hunts for the opening flag, strips the zeros the far end inserted after runs of five ones, and assembles bytes least significant bit first. It checks the 16-bit frame check sequence and never forwards the two check bytes. Each byte handed to the queue carries a two-bit tag that marks its place in the packet and, on the closing byte, whether the packet passed.

Station filtering is optional. When it is switched on, a frame whose first byte matches neither the programmed station address nor the broadcast value is dropped without a trace. The receiver also flags a line that sits at all ones and reports frames cut short by an abort sequence. Clearing the enable is graceful: a packet already under way is received to its end before the receiver goes quiet.

Top module: `hdlc_rx_filter`

## Requirements
- R1: After `rxEnable` rises the receiver searches for the flag pattern 0x7E (bits 0,1,1,1,1,1,1,0 in line order) and opens a frame on it; bytes are assembled least significant bit first, and only bits strobed by `bitValid` are taken.
- R2: Inside a frame, a zero that follows five consecutive ones is discarded and does not count as data.
- R3: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, bit-reflected, preset to 0xFFFF, sent inverted and low byte first; a frame of at least 4 bytes, a whole number of bytes long, whose residue over all bytes is 0xF0B8 ends with tag 10, any other closed frame with tag 11.
- R4: Tags are 01 for the first byte of a packet and 00 for each byte between the first and the last.
- R5: The two check bytes are never written; a frame of exactly 3 bytes writes its single data byte with tag 11, and a frame shorter than 3 bytes writes nothing.
- R6: With `addrMatchEn` set, a frame whose first byte equals neither `stationAddr` nor 0xFF writes nothing; with it clear every frame is accepted.
- R7: Seven consecutive ones inside a frame holding at least one complete byte pulse `abortPulse` for one cycle; if 4 or more bytes were complete, the byte two places before the newest complete byte is written with tag 11, otherwise nothing is written.
- R8: `idleChannel` is high while the last 15 or more received bits were all ones, and low after a zero.
- R9: `idleValid` is low after enabling and goes high once 15 bits have been received or as soon as a zero is received, whichever comes first.
- R10: Clearing `rxEnable` while a frame holds received bytes lets that frame finish and be written; afterwards the receiver ignores the line until enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Strobe qualifying `bitIn` for one clock |
| bitIn | input | 1 | Serial line bit |
| rxEnable | input | 1 | Receiver enable |
| addrMatchEn | input | 1 | Turns on station address filtering |
| stationAddr | input | 8 | Station address compared with the first byte |
| fifoWrEn | output | 1 | One-cycle write strobe toward the receive queue |
| fifoWrData | output | 8 | Byte being written |
| fifoWrTag | output | 2 | Position and status tag of the byte |
| abortPulse | output | 1 | One-cycle pulse on an aborted frame |
| idleChannel | output | 1 | Line has shown at least 15 consecutive ones |
| idleValid | output | 1 | Idle indication is meaningful |

## Verification
The hardest situations to reach are those that depend on exact byte counts at the moment a frame ends: an abort arriving after a given number of complete bytes, frames of two and three bytes, and a disable landing in the middle of a packet. Directed frames place each of these ends at a chosen byte, while random payloads with random lengths, address choices and corrupted check sequences produce long runs of ones that force zero removal and check-byte patterns of every shape.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 4;
  localparam int FCS_BYTES = 2;
  localparam int PIPE      = FCS_BYTES + 1;
  localparam int MIN_GOOD  = FCS_BYTES + 2;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [7:0]  ALL_CALL    = 8'hFF;

  localparam logic [1:0] TAG_MID      = 2'b00;
  localparam logic [1:0] TAG_FIRST    = 2'b01;
  localparam logic [1:0] TAG_GOOD_END = 2'b10;
  localparam logic [1:0] TAG_BAD_END  = 2'b11;

  typedef enum logic [1:0] {ST_HUNT, ST_FRAME, ST_SKIP} rxStateE;

  // strobes from control into the datapath
  typedef struct packed {
    logic       run;
    logic       openFrame;
    logic       emit;
    logic [1:0] emitTag;
  } rxCtlS;

  // events and counters from the datapath into control
  typedef struct packed {
    logic              evFlag;
    logic              evAbort;
    logic              byteDone;
    logic [BYTE_W-1:0] newByte;
    logic [CNT_W-1:0]  byteCnt;
    logic [2:0]        bitCnt;
    logic              crcOk;
  } rxStatS;

  function automatic logic [15:0] crc16Byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_dp.sv
module hdlc_rx_dp
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  input  rxCtlS             ctl,
  output rxStatS            stat,
  output logic              fifoWrEn,
  output logic [BYTE_W-1:0] fifoWrData,
  output logic [1:0]        fifoWrTag,
  output logic              idleChannel,
  output logic              idleValid
);
  localparam int ONES_W = $clog2(IDLE_RUN + 1);
  localparam logic [ONES_W-1:0] RUN_MAX  = ONES_W'(IDLE_RUN);
  localparam logic [ONES_W-1:0] RUN_FIVE = ONES_W'(5);
  localparam logic [ONES_W-1:0] RUN_SIX  = ONES_W'(6);

  logic [ONES_W-1:0] onesRun;
  logic [ONES_W-1:0] seenCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [2:0]        bitCnt;
  logic [CNT_W-1:0]  byteCnt;
  logic [15:0]       crcReg;
  logic [BYTE_W-1:0] pipeQ [PIPE];

  logic step, atFive, atSix, stuffBit, dataStep, byteDone;
  logic [BYTE_W-1:0] newByte;

  always_comb begin
    step     = bitValid & ctl.run;
    atFive   = (onesRun == RUN_FIVE);
    atSix    = (onesRun == RUN_SIX);
    stuffBit = step & ~bitIn & atFive;
    dataStep = step & ~stuffBit & ~atSix;
    byteDone = dataStep & (bitCnt == 3'd7);
    newByte  = {bitIn, shiftReg[BYTE_W-1:1]};
  end

  always_comb begin
    stat.evFlag   = step & ~bitIn & atSix;
    stat.evAbort  = step &  bitIn & atSix;
    stat.byteDone = byteDone;
    stat.newByte  = newByte;
    stat.byteCnt  = byteCnt;
    stat.bitCnt   = bitCnt;
    stat.crcOk    = (crcReg == CRC_RESIDUE);
  end

  // run of ones and idle tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesRun   <= '0;
      seenCnt   <= '0;
      idleValid <= 1'b0;
    end else if (!ctl.run) begin
      onesRun   <= '0;
      seenCnt   <= '0;
      idleValid <= 1'b0;
    end else if (step) begin
      if (!bitIn)                  onesRun <= '0;
      else if (onesRun != RUN_MAX) onesRun <= onesRun + 1'b1;
      if (seenCnt != RUN_MAX) seenCnt <= seenCnt + 1'b1;
      if (!bitIn || seenCnt == RUN_MAX - 1'b1) idleValid <= 1'b1;
    end
  end

  assign idleChannel = ctl.run & (onesRun == RUN_MAX);

  // byte assembly and check sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      crcReg   <= CRC_PRESET;
    end else if (ctl.openFrame) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      crcReg   <= CRC_PRESET;
    end else if (dataStep) begin
      shiftReg <= newByte;
      bitCnt   <= bitCnt + 1'b1;
      if (byteDone) begin
        if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
        crcReg <= crc16Byte(crcReg, newByte);
      end
    end
  end

  // hold line: newest bytes wait here until it is known they are not check bytes
  for (genvar s = 0; s < PIPE; s++) begin : g_pipe
    if (s == PIPE - 1) begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         pipeQ[s] <= '0;
        else if (byteDone) pipeQ[s] <= newByte;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         pipeQ[s] <= '0;
        else if (byteDone) pipeQ[s] <= pipeQ[s+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
      fifoWrTag  <= TAG_MID;
    end else begin
      fifoWrEn <= ctl.emit;
      if (ctl.emit) begin
        fifoWrData <= pipeQ[0];
        fifoWrTag  <= ctl.emitTag;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_ctl.sv
module hdlc_rx_ctl
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              addrMatchEn,
  input  logic [BYTE_W-1:0] stationAddr,
  input  rxStatS            stat,
  output rxCtlS             ctl,
  output logic              abortPulse,
  output logic              rxActive
);
  localparam logic [CNT_W-1:0] CNT_PIPE = CNT_W'(PIPE);
  localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(MIN_GOOD);

  rxStateE state, stateNext;
  logic inPacket, closeGood, addrReject;

  always_comb begin
    inPacket   = (state == ST_FRAME) && (stat.byteCnt != '0);
    closeGood  = (stat.byteCnt >= CNT_GOOD) && (stat.bitCnt == 3'd7) && stat.crcOk;
    addrReject = (state == ST_FRAME) && stat.byteDone && (stat.byteCnt == '0) &&
                 addrMatchEn && (stat.newByte != stationAddr) && (stat.newByte != ALL_CALL);

    ctl.run       = rxActive;
    ctl.openFrame = stat.evFlag;
    ctl.emit      = 1'b0;
    ctl.emitTag   = TAG_MID;
    if (state == ST_FRAME) begin
      if (stat.evFlag && stat.byteCnt >= CNT_PIPE) begin
        ctl.emit    = 1'b1;
        ctl.emitTag = closeGood ? TAG_GOOD_END : TAG_BAD_END;
      end else if (stat.evAbort && stat.byteCnt > CNT_PIPE) begin
        ctl.emit    = 1'b1;
        ctl.emitTag = TAG_BAD_END;
      end else if (stat.byteDone && stat.byteCnt >= CNT_PIPE) begin
        ctl.emit    = 1'b1;
        ctl.emitTag = (stat.byteCnt == CNT_PIPE) ? TAG_FIRST : TAG_MID;
      end
    end

    stateNext = state;
    if (!rxActive)         stateNext = ST_HUNT;
    else if (stat.evFlag)  stateNext = ST_FRAME;
    else if (stat.evAbort) stateNext = ST_HUNT;
    else if (addrReject)   stateNext = ST_SKIP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HUNT;
      rxActive   <= 1'b0;
      abortPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      rxActive   <= rxEnable | inPacket;
      abortPulse <= (state == ST_FRAME) && stat.evAbort && (stat.byteCnt != '0);
    end
  end
endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  input  logic        bitIn,
  input  logic        rxEnable,
  input  logic        addrMatchEn,
  input  logic [7:0]  stationAddr,
  output logic        fifoWrEn,
  output logic [7:0]  fifoWrData,
  output logic [1:0]  fifoWrTag,
  output logic        abortPulse,
  output logic        idleChannel,
  output logic        idleValid
);
  rxCtlS  ctlBus;
  rxStatS statBus;
  logic   rxActive;

  hdlc_rx_ctl u_ctl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .addrMatchEn(addrMatchEn),
    .stationAddr(stationAddr), .stat(statBus), .ctl(ctlBus),
    .abortPulse(abortPulse), .rxActive(rxActive)
  );

  hdlc_rx_dp #(.IDLE_RUN(IDLE_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn), .ctl(ctlBus),
    .stat(statBus), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoWrTag(fifoWrTag), .idleChannel(idleChannel), .idleValid(idleValid)
  );
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       rxActive,
  input logic       fifoWrEn,
  input logic [1:0] fifoWrTag,
  input logic       abortPulse,
  input logic       idleChannel,
  input logic       idleValid
);
  logic lastEnded;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lastEnded <= 1'b1;
    else if (fifoWrEn) lastEnded <= fifoWrTag[1];
  end

  AST_WR_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(bitValid)); // R1
  AST_PACKET_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && lastEnded) |-> (fifoWrTag == 2'b01 || fifoWrTag == 2'b11)); // R4
  AST_NO_SECOND_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && !lastEnded) |-> (fifoWrTag != 2'b01)); // R4
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse); // R7
  AST_IDLE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    idleChannel |-> idleValid); // R9
  AST_WR_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(rxActive)); // R10
endmodule

bind hdlc_rx_filter hdlc_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxActive(rxActive),
  .fifoWrEn(fifoWrEn), .fifoWrTag(fifoWrTag), .abortPulse(abortPulse),
  .idleChannel(idleChannel), .idleValid(idleValid)
);

// File: tb/sim_hdlc_rx_filter.sv
module sim_hdlc_rx_filter;
  logic clk = 1'b0;
  logic rstN, bitValid, bitIn, rxEnable, addrMatchEn;
  logic [7:0] stationAddr;
  logic fifoWrEn, abortPulse, idleChannel, idleValid;
  logic [7:0] fifoWrData;
  logic [1:0] fifoWrTag;

  int total = 0;
  int bad = 0;
  int abortCnt = 0;
  int stuffOnes = 0;
  logic [7:0] expData[$], gotData[$];
  logic [1:0] expTag[$], gotTag[$];

  always #10 clk = ~clk;

  hdlc_rx_filter u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn), .rxEnable(rxEnable),
    .addrMatchEn(addrMatchEn), .stationAddr(stationAddr), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .fifoWrTag(fifoWrTag), .abortPulse(abortPulse),
    .idleChannel(idleChannel), .idleValid(idleValid)
  );

  always @(negedge clk) begin
    if (fifoWrEn) begin
      gotData.push_back(fifoWrData);
      gotTag.push_back(fifoWrTag);
    end
    if (abortPulse) abortCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic sendRaw(input logic b);
    @(negedge clk); bitIn = b; bitValid = 1'b1;
    @(negedge clk); bitValid = 1'b0;
  endtask

  task automatic sendFlag();
    sendRaw(0); for (int i = 0; i < 6; i++) sendRaw(1); sendRaw(0);
    stuffOnes = 0;
  endtask

  task automatic sendDataBit(input logic b);
    sendRaw(b);
    if (b) begin
      stuffOnes++;
      if (stuffOnes == 5) begin sendRaw(0); stuffOnes = 0; end
    end else stuffOnes = 0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendDataBit(v[i]);
  endtask

  // body, check bytes (optionally corrupted), closing flag; disableAt drops the enable
  task automatic sendFrame(input logic [7:0] d[$], input bit corrupt, input int disableAt);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    for (int i = 0; i < d.size(); i++) begin
      if (i == disableAt) rxEnable = 1'b0;
      c = crcStep(c, d[i]);
      sendByte(d[i]);
    end
    fcs = ~c;
    if (corrupt) fcs = fcs ^ 16'h0100;
    sendByte(fcs[7:0]);
    sendByte(fcs[15:8]);
    sendFlag();
  endtask

  task automatic expectFrame(input logic [7:0] d[$], input bit good, input bit accepted);
    int n = d.size();
    if (!accepted || n == 0) return;
    for (int i = 0; i < n; i++) begin
      expData.push_back(d[i]);
      if (i == n - 1)  expTag.push_back((good && n + 2 >= 4) ? 2'b10 : 2'b11);
      else if (i == 0) expTag.push_back(2'b01);
      else             expTag.push_back(2'b00);
    end
  endtask

  task automatic compareAll(input string req);
    repeat (4) @(negedge clk);
    chk(gotData.size() == expData.size(), {req, " count"}, gotData.size(), expData.size());
    for (int i = 0; i < expData.size() && i < gotData.size(); i++) begin
      chk(gotData[i] == expData[i], {req, " data"}, gotData[i], expData[i]);
      chk(gotTag[i] == expTag[i], {req, " tag"}, gotTag[i], expTag[i]);
    end
    gotData.delete(); gotTag.delete(); expData.delete(); expTag.delete();
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] fr[$];
    int a0;
    void'($urandom(32'd4242));
    rstN = 0; bitValid = 0; bitIn = 0; rxEnable = 0; addrMatchEn = 0; stationAddr = 8'h35;
    repeat (3) @(negedge clk);
    chk(fifoWrEn == 0, "R1 reset wr", fifoWrEn, 0);
    chk(abortPulse == 0, "R7 reset abort", abortPulse, 0);
    chk(idleChannel == 0, "R8 reset idle", idleChannel, 0);
    chk(idleValid == 0, "R9 reset valid", idleValid, 0);
    rstN = 1;
    @(negedge clk); rxEnable = 1; repeat (2) @(negedge clk);

    // R8 / R9: fifteen ones
    for (int i = 0; i < 14; i++) sendRaw(1);
    chk(idleValid == 0, "R9 before 15 bits", idleValid, 0);
    chk(idleChannel == 0, "R8 14 ones", idleChannel, 0);
    sendRaw(1);
    chk(idleChannel == 1, "R8 15 ones", idleChannel, 1);
    chk(idleValid == 1, "R9 after 15 bits", idleValid, 1);
    sendRaw(0);
    chk(idleChannel == 0, "R8 zero clears", idleChannel, 0);

    // R9: first zero validates
    rxEnable = 0; repeat (3) @(negedge clk);
    rxEnable = 1; repeat (2) @(negedge clk);
    chk(idleValid == 0, "R9 after re-enable", idleValid, 0);
    sendRaw(0);
    chk(idleValid == 1, "R9 first zero", idleValid, 1);

    // R1 R2 R3 R4: good frame with stuffing-heavy data
    sendFlag();
    fr = '{8'h12, 8'h7E, 8'hFF, 8'h3F, 8'h56};
    sendFrame(fr, 0, -1); expectFrame(fr, 1, 1); compareAll("R2 R3 good");
    // R3: corrupted check sequence
    fr = '{8'h21, 8'h43, 8'h65};
    sendFrame(fr, 1, -1); expectFrame(fr, 0, 1); compareAll("R3 bad fcs");
    // R5: 3-byte and 2-byte frames
    fr = '{8'hA5};
    sendFrame(fr, 0, -1); expectFrame(fr, 0, 1); compareAll("R5 three bytes");
    fr = {};
    sendFrame(fr, 0, -1); compareAll("R5 two bytes");

    // R6: address filter
    addrMatchEn = 1;
    fr = '{8'h35, 8'h01, 8'h02}; sendFrame(fr, 0, -1); expectFrame(fr, 1, 1); compareAll("R6 own addr");
    fr = '{8'hFF, 8'h09};        sendFrame(fr, 0, -1); expectFrame(fr, 1, 1); compareAll("R6 all call");
    fr = '{8'h36, 8'h01, 8'h02}; sendFrame(fr, 0, -1); compareAll("R6 reject");
    addrMatchEn = 0;
    fr = '{8'h36, 8'h0A};        sendFrame(fr, 0, -1); expectFrame(fr, 1, 1); compareAll("R6 filter off");

    // R7: abort after five bytes, then after two
    a0 = abortCnt;
    fr = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    foreach (fr[i]) sendByte(fr[i]);
    for (int i = 0; i < 7; i++) sendRaw(1);
    sendFlag();
    expData = '{8'h01, 8'h02, 8'h03}; expTag = '{2'b01, 2'b00, 2'b11};
    compareAll("R7 abort long");
    chk(abortCnt == a0 + 1, "R7 pulse long", abortCnt, a0 + 1);
    sendByte(8'h11); sendByte(8'h22);
    for (int i = 0; i < 7; i++) sendRaw(1);
    sendFlag();
    compareAll("R7 abort short");
    chk(abortCnt == a0 + 2, "R7 pulse short", abortCnt, a0 + 2);

    // R10: disable mid-packet
    fr = '{8'h11, 8'h22, 8'h33};
    sendFrame(fr, 0, 2); expectFrame(fr, 1, 1); compareAll("R10 finish packet");
    fr = '{8'h44, 8'h55, 8'h66};
    sendFlag(); sendFrame(fr, 0, -1); compareAll("R10 ignored after");
    chk(idleValid == 0, "R10 idle off", idleValid, 0);
    rxEnable = 1; repeat (2) @(negedge clk);
    sendFlag();

    // random frames
    for (int k = 0; k < 40; k++) begin
      int len = 1 + ($urandom % 6);
      bit corrupt = ($urandom % 4) == 0;
      bit acc;
      addrMatchEn = $urandom % 2;
      stationAddr = $urandom;
      fr = {};
      for (int i = 0; i < len; i++) fr.push_back(8'($urandom));
      case ($urandom % 3)
        0: fr[0] = stationAddr;
        1: fr[0] = 8'hFF;
        default: ;
      endcase
      acc = !addrMatchEn || fr[0] == stationAddr || fr[0] == 8'hFF;
      sendFrame(fr, corrupt, -1);
      expectFrame(fr, !corrupt, acc);
      compareAll("R3 R4 R6 random");
      if ($urandom % 2) sendFlag();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule